// File: doc/BRIEF.md
# Pattern-Table Bank Mapper with ROM/RAM Chip Select

This block sits between a CPU write port and a video pattern-fetch bus. The CPU programs six pattern bank registers indirectly. It first writes an index to a select register, and then writes a value that lands in the register named by that index. The video side presents a 14-bit address with read and write strobes. The block answers with a physical pattern address, separate enables for a pattern ROM chip and a pattern RAM chip, and a RAM write strobe. All of these outputs are registered one clock after the video request.

Each bank value carries a chip-select bit beside its bank number. The bit does not extend the ROM address. It routes the window to the RAM chip instead of the ROM chip. Software can therefore place ROM pages and writable RAM pages side by side within one pattern table.

Two 2 KiB windows and four 1 KiB windows cover the 8 KiB pattern space. An inversion flag swaps the halves that the two window sizes occupy. Writes to register indices 6 and 7 are accepted and have no effect on pattern mapping.

Top module: `chr_bank_mapper`

## Requirements
- R1: After synchronous reset, all six bank registers, the index and the inversion flag are zero. Every pattern access then goes to ROM, bank 0 (with bit 0 taken from video A10 in a 2 KiB window). No enable is active during or directly after reset.
- R2: A CPU write with address bits 15..13 = 3'b100 and A0 = 0 is a select write. Data bits 2..0 become the index and data bit 7 becomes the inversion flag. With A0 = 1 the write is a data write, and its bits 6..0 go to the bank register named by the index.
- R3: Without inversion, video A12 = 0 selects a 2 KiB window: register 0 when A11 = 0 and register 1 when A11 = 1. The physical ROM address is {bank[5:1], A10, A9..A0}.
- R4: Without inversion, video A12 = 1 selects a 1 KiB window, register 2 + A11..A10. The physical ROM address is {bank[5:0], A9..A0}.
- R5: With the inversion flag set, the 2 KiB windows serve A12 = 1 and the 1 KiB windows serve A12 = 0. Windows are otherwise indexed as in R3 and R4.
- R6: Bank value bit 6 = 0 asserts the ROM enable and bit 6 = 1 asserts the RAM enable, for the window being accessed.
- R7: The RAM address is {bank[2:0], A9..A0}, with the same A10 substitution in 2 KiB windows. The RAM write strobe is asserted only for a video write to a window with bit 6 set.
- R8: The ROM and RAM enables are never active together. Neither is active unless a video read or write targets an address with A13 = 0.
- R9: A data write while the index is 6 or 7 changes no mapping. A CPU write outside $8000-$9FFF changes no mapping. Data bit 7 of a bank value is ignored.
- R10: Outputs appear on the clock edge after the video request. Address bits 9..0 pass through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU write address |
| cpu_data | input | 8 | CPU write data |
| cpu_we | input | 1 | CPU write strobe |
| vid_addr | input | 14 | Video pattern address |
| vid_rd | input | 1 | Video read strobe |
| vid_we | input | 1 | Video write strobe |
| pat_addr | output | 16 | Physical pattern ROM address (registered) |
| ram_addr | output | 13 | Physical pattern RAM address (registered) |
| rom_en | output | 1 | Pattern ROM chip enable (registered) |
| ram_en | output | 1 | Pattern RAM chip enable (registered) |
| ram_we | output | 1 | Pattern RAM write strobe (registered) |

## Verification
A corrupted bank register, index or inversion flag has no effect until a video access reaches the affected window. On that access it shows up one clock later, either as wrong upper address bits or as the enable of the wrong chip. The bench therefore probes each window after every mapping change, and again after the writes that are meant to be ignored. A wrong chip-select bit is the most damaging fault, because it can produce a RAM write strobe on a window that should be read-only ROM. For that reason every video write is checked for its strobe.

// File: rtl/chr_map_pkg.sv
package chr_map_pkg;
  // CPU register decode kinds
  typedef enum logic [1:0] {
    CW_NONE = 2'd0,
    CW_SEL  = 2'd1,
    CW_DATA = 2'd2
  } cpu_wr_kind_e;

  // Result of the window lookup for one video access
  typedef struct packed {
    logic       hit;     // access to pattern space
    logic       cs_ram;  // window mapped to RAM
    logic [5:0] bank;    // effective bank number
  } win_sel_t;
endpackage

// File: rtl/chr_reg_file.sv
module chr_reg_file
  import chr_map_pkg::*;
#(
  parameter int CPU_AW = 16,
  parameter int DW     = 8,
  parameter int NREG   = 6,
  parameter int VW     = 7,
  parameter int IDXW   = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [CPU_AW-1:0]        cpu_addr,
  input  logic [DW-1:0]            cpu_data,
  input  logic                     cpu_we,
  output logic [NREG-1:0][VW-1:0]  bank_q,
  output logic                     inv_q
);
  localparam logic [2:0] WIN_TAG = 3'b100;

  cpu_wr_kind_e     kind;
  logic [IDXW-1:0]  idx_q;
  logic             unused_bits;

  always_comb begin
    kind = CW_NONE;
    if (cpu_we && cpu_addr[CPU_AW-1 -: 3] == WIN_TAG)
      kind = cpu_addr[0] ? CW_DATA : CW_SEL;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
      inv_q <= 1'b0;
    end else if (kind == CW_SEL) begin
      idx_q <= cpu_data[IDXW-1:0];
      inv_q <= cpu_data[DW-1];
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst)
        bank_q[g] <= '0;
      else if (kind == CW_DATA && idx_q == IDXW'(g))
        bank_q[g] <= cpu_data[VW-1:0];
    end
  end

  assign unused_bits = ^{cpu_addr[CPU_AW-4:1], cpu_data[DW-1:VW], cpu_data[DW-2:IDXW]};
endmodule

// File: rtl/chr_window_sel.sv
module chr_window_sel
  import chr_map_pkg::*;
#(
  parameter int VAW   = 14,
  parameter int NREG  = 6,
  parameter int BANKW = 6,
  parameter int VW    = BANKW + 1
) (
  input  logic [VAW-1:0]           vid_addr,
  input  logic                     vid_act,
  input  logic                     inv,
  input  logic [NREG-1:0][VW-1:0]  bank_q,
  output win_sel_t                 sel
);
  localparam int CS_BIT = BANKW;
  localparam int FIRST_1K = 2;

  logic           half_hi;
  logic [2:0]     ri;
  logic [VW-1:0]  val;
  logic [BANKW-1:0] bk;

  always_comb begin
    half_hi = vid_addr[12] ^ inv;
    if (!half_hi)
      ri = {2'b00, vid_addr[11]};
    else
      ri = 3'(FIRST_1K) + {1'b0, vid_addr[11:10]};
    val = bank_q[ri];
    bk  = val[BANKW-1:0];
    if (!half_hi)
      bk[0] = vid_addr[10];
    sel.hit    = vid_act && !vid_addr[VAW-1];
    sel.cs_ram = val[CS_BIT];
    sel.bank   = 6'(bk);
  end
endmodule

// File: rtl/chr_out_stage.sv
module chr_out_stage
  import chr_map_pkg::*;
#(
  parameter int OFFW  = 10,
  parameter int BANKW = 6,
  parameter int RAMBW = 3,
  parameter int PAW   = BANKW + OFFW,
  parameter int RAW   = RAMBW + OFFW
) (
  input  logic              clk,
  input  logic              rst,
  input  win_sel_t          sel,
  input  logic [OFFW-1:0]   offs,
  input  logic              wr,
  output logic [PAW-1:0]    pat_addr,
  output logic [RAW-1:0]    ram_addr,
  output logic              rom_en,
  output logic              ram_en,
  output logic              ram_we
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pat_addr <= '0;
      ram_addr <= '0;
      rom_en   <= 1'b0;
      ram_en   <= 1'b0;
      ram_we   <= 1'b0;
    end else begin
      pat_addr <= {sel.bank[BANKW-1:0], offs};
      ram_addr <= {sel.bank[RAMBW-1:0], offs};
      rom_en   <= sel.hit && !sel.cs_ram;
      ram_en   <= sel.hit && sel.cs_ram;
      ram_we   <= sel.hit && sel.cs_ram && wr;
    end
  end
endmodule

// File: rtl/chr_bank_mapper.sv
module chr_bank_mapper
  import chr_map_pkg::*;
#(
  parameter int CPU_AW = 16,
  parameter int DW     = 8,
  parameter int VAW    = 14,
  parameter int NREG   = 6,
  parameter int BANKW  = 6,
  parameter int RAMBW  = 3,
  parameter int OFFW   = 10,
  parameter int PAW    = BANKW + OFFW,
  parameter int RAW    = RAMBW + OFFW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic [DW-1:0]     cpu_data,
  input  logic              cpu_we,
  input  logic [VAW-1:0]    vid_addr,
  input  logic              vid_rd,
  input  logic              vid_we,
  output logic [PAW-1:0]    pat_addr,
  output logic [RAW-1:0]    ram_addr,
  output logic              rom_en,
  output logic              ram_en,
  output logic              ram_we
);
  localparam int VW = BANKW + 1;

  logic [NREG-1:0][VW-1:0] bank_q;
  logic                    inv_q;
  win_sel_t                sel;

  chr_reg_file #(.CPU_AW(CPU_AW), .DW(DW), .NREG(NREG), .VW(VW), .IDXW(3)) u_regs (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
    .cpu_we(cpu_we), .bank_q(bank_q), .inv_q(inv_q)
  );

  chr_window_sel #(.VAW(VAW), .NREG(NREG), .BANKW(BANKW), .VW(VW)) u_win (
    .vid_addr(vid_addr), .vid_act(vid_rd | vid_we), .inv(inv_q),
    .bank_q(bank_q), .sel(sel)
  );

  chr_out_stage #(.OFFW(OFFW), .BANKW(BANKW), .RAMBW(RAMBW), .PAW(PAW), .RAW(RAW)) u_out (
    .clk(clk), .rst(rst), .sel(sel), .offs(vid_addr[OFFW-1:0]), .wr(vid_we),
    .pat_addr(pat_addr), .ram_addr(ram_addr), .rom_en(rom_en),
    .ram_en(ram_en), .ram_we(ram_we)
  );
endmodule

// File: rtl/chr_map_checker.sv
module chr_map_checker #(
  parameter int VAW  = 14,
  parameter int OFFW = 10,
  parameter int PAW  = 16,
  parameter int RAW  = 13
) (
  input logic             clk,
  input logic             rst,
  input logic [VAW-1:0]   vid_addr,
  input logic             vid_rd,
  input logic             vid_we,
  input logic [PAW-1:0]   pat_addr,
  input logic [RAW-1:0]   ram_addr,
  input logic             rom_en,
  input logic             ram_en,
  input logic             ram_we
);
  // R8: chip enables exclusive
  p_enables_exclusive_r8: assert property (@(posedge clk) disable iff (rst)
    !(rom_en && ram_en));

  // R8: no request or high address gives no enable next cycle
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (!(vid_rd || vid_we) || vid_addr[VAW-1]) |=> (!rom_en && !ram_en));

  // R7: RAM write strobe only with RAM enable
  p_ramwe_needs_ram_r7: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> ram_en);

  // R7: a read-only request never strobes RAM write
  p_read_no_we_r7: assert property (@(posedge clk) disable iff (rst)
    (vid_rd && !vid_we) |=> !ram_we);

  // R10: offset bits pass through one cycle later
  p_offset_pass_r10: assert property (@(posedge clk) disable iff (rst)
    (vid_rd || vid_we) |=> (pat_addr[OFFW-1:0] == $past(vid_addr[OFFW-1:0]) &&
                            ram_addr[OFFW-1:0] == $past(vid_addr[OFFW-1:0])));
endmodule

bind chr_bank_mapper chr_map_checker #(.VAW(VAW), .OFFW(OFFW), .PAW(PAW), .RAW(RAW)) u_chk (
  .clk(clk), .rst(rst), .vid_addr(vid_addr), .vid_rd(vid_rd), .vid_we(vid_we),
  .pat_addr(pat_addr), .ram_addr(ram_addr), .rom_en(rom_en), .ram_en(ram_en),
  .ram_we(ram_we)
);

// File: tb/sim_chr_bank_mapper.sv
module sim_chr_bank_mapper;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_data = '0;
  logic        cpu_we = 1'b0;
  logic [13:0] vid_addr = '0;
  logic        vid_rd = 1'b0;
  logic        vid_we = 1'b0;
  logic [15:0] pat_addr;
  logic [12:0] ram_addr;
  logic        rom_en, ram_en, ram_we;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  chr_bank_mapper u0 (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_data(cpu_data), .cpu_we(cpu_we),
    .vid_addr(vid_addr), .vid_rd(vid_rd), .vid_we(vid_we),
    .pat_addr(pat_addr), .ram_addr(ram_addr), .rom_en(rom_en), .ram_en(ram_en),
    .ram_we(ram_we)
  );

  typedef struct {
    logic        rom, ram, we, chk;
    logic [15:0] pa;
    logic [12:0] ra;
    string       tag;
  } exp_t;
  exp_t q[$];

  // requirement model
  logic [6:0] m_bank [6];
  logic [2:0] m_idx;
  logic       m_inv;

  function automatic exp_t predict(logic [13:0] a, logic rd, logic we, string tag);
    exp_t e;
    logic act, hi, cs;
    int ri;
    logic [5:0] bk;
    act = (rd || we) && !a[13];
    hi  = a[12] ^ m_inv;
    ri  = hi ? 2 + int'(a[11:10]) : int'(a[11]);
    bk  = m_bank[ri][5:0];
    if (!hi) bk[0] = a[10];
    cs  = m_bank[ri][6];
    e.rom = act && !cs;
    e.ram = act && cs;
    e.we  = act && cs && we;
    e.chk = act;
    e.pa  = {bk, a[9:0]};
    e.ra  = {bk[2:0], a[9:0]};
    e.tag = tag;
    return e;
  endfunction

  task automatic cpu_wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_data = d; cpu_we = 1'b1;
    if (a[15:13] == 3'b100) begin
      if (!a[0]) begin m_idx = d[2:0]; m_inv = d[7]; end
      else if (m_idx < 3'd6) m_bank[m_idx] = d[6:0];
    end
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  task automatic bank(int r, logic [7:0] v);
    cpu_wr(16'h8000, {m_inv, 4'b0, 3'(r)});
    cpu_wr(16'h8001, v);
  endtask

  task automatic vacc(logic [13:0] a, logic rd, logic we, string tag);
    @(negedge clk);
    vid_addr = a; vid_rd = rd; vid_we = we;
    q.push_back(predict(a, rd, we, tag));
    @(negedge clk);
    vid_rd = 1'b0; vid_we = 1'b0;
  endtask

  // monitor
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      vectors++;
      if (rom_en !== e.rom || ram_en !== e.ram || ram_we !== e.we ||
          (e.chk && (pat_addr !== e.pa || ram_addr !== e.ra))) begin
        miscompares++;
        $display("FAIL %s addr=%h: got rom=%b ram=%b we=%b pa=%h ra=%h exp rom=%b ram=%b we=%b pa=%h ra=%h",
                 e.tag, vid_addr, rom_en, ram_en, ram_we, pat_addr, ram_addr,
                 e.rom, e.ram, e.we, e.pa, e.ra);
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 6; i++) m_bank[i] = '0;
    m_idx = '0; m_inv = 1'b0;
    repeat (3) @(negedge clk);
    // R1: enables quiet during reset
    vectors++;
    if (rom_en !== 1'b0 || ram_en !== 1'b0) begin
      miscompares++;
      $display("FAIL R1 reset: got rom=%b ram=%b exp 0 0", rom_en, ram_en);
    end
    rst = 1'b0;
    // R1: reset map is ROM bank 0
    vacc(14'h0000, 1, 0, "R1");
    vacc(14'h0400, 1, 0, "R1");
    vacc(14'h1C05, 1, 0, "R1");
    // R2/R3: 2 KiB windows
    bank(0, 8'h0A);
    bank(1, 8'h15);
    vacc(14'h0000, 1, 0, "R3");
    vacc(14'h0400, 1, 0, "R3");
    vacc(14'h0800, 1, 0, "R2");
    vacc(14'h0C33, 1, 0, "R3");
    // R4/R6: 1 KiB windows, one RAM
    bank(2, 8'h21);
    bank(3, 8'h3F);
    bank(4, 8'h42);
    bank(5, 8'h07);
    vacc(14'h1000, 1, 0, "R4");
    vacc(14'h17FF, 1, 0, "R4");
    vacc(14'h1800, 1, 0, "R6");
    vacc(14'h1C12, 1, 0, "R4");
    // R7: RAM writes and ROM-window writes
    vacc(14'h1805, 0, 1, "R7");
    vacc(14'h1000, 0, 1, "R7");
    bank(5, 8'h4D);
    vacc(14'h1E01, 1, 0, "R7");
    vacc(14'h1E02, 0, 1, "R7");
    bank(0, 8'h43);
    vacc(14'h0401, 0, 1, "R7");
    vacc(14'h0001, 1, 0, "R6");
    // R5: inversion
    cpu_wr(16'h8000, 8'h80);
    vacc(14'h0000, 1, 0, "R5");
    vacc(14'h0C00, 1, 0, "R5");
    vacc(14'h1000, 1, 0, "R5");
    vacc(14'h1C10, 1, 0, "R5");
    cpu_wr(16'h9FFE, 8'h00);
    vacc(14'h0000, 1, 0, "R5");
    // R9: ignored writes
    cpu_wr(16'h8000, 8'h06); cpu_wr(16'h8001, 8'hFF);
    cpu_wr(16'h8000, 8'h07); cpu_wr(16'h9FFF, 8'hFF);
    cpu_wr(16'h8000, 8'h02); cpu_wr(16'hA001, 8'h55); cpu_wr(16'h7FFF, 8'h55);
    for (int k = 0; k < 8; k++) vacc(14'(k * 14'h0400), 1, 0, "R9");
    bank(1, 8'h95);
    vacc(14'h0800, 1, 0, "R9");
    // R8: no access / high address
    vacc(14'h2000, 1, 0, "R8");
    vacc(14'h3805, 0, 1, "R8");
    vacc(14'h1800, 0, 0, "R8");
    // R10: back-to-back accesses
    vacc(14'h0A5A, 1, 0, "R10");
    vacc(14'h1BCD, 1, 0, "R10");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule